// File: doc/BRIEF.md
# DMA Channel Interrupt Register Set

This block holds the interrupt registers of a single DMA channel. Two hardware event lines feed it: one reports that a transfer has completed, the other that an abort has been accepted. Software can read four views of these events through a small address/data register port:
- the live level of each line;
- a sticky request register that software clears by writing 1;
- an enable mask;
- a read-only detect view, which is the request register ANDed with the mask.

The interrupt output is high whenever the detect view is nonzero. Several channels can OR their outputs onto one shared line. A handler that reads a detect value of zero knows this channel did not raise the interrupt. Software can also poll a request bit directly, without enabling it. This is the usual way to wait for an abort to be acknowledged.

Top module: `chan_irq_regs`

## Requirements
- R1: After reset, the request and enable registers read zero and `irq_o` is low.
- R2: Address 0x10 is a read-only view of the live event levels, with no register delay. Completion is bit 1 and abort is bit 13.
- R3: A request bit at address 0x14 is set by the clock edge that first samples its event line high. It stays set after the line falls.
- R4: Writing address 0x14 clears each request bit where the write data has a 1. Bits where the write data has a 0 keep their value.
- R5: If an event rises in the same cycle as a write of 1 to its request bit, the bit is left set.
- R6: The enable register at address 0x18 stores bits 1 and 13 of the write data and reads back what was stored.
- R7: Address 0x1C reads the request bits ANDed with the enable bits. Writes to this address do nothing.
- R8: `irq_o` is high exactly when the detect view is nonzero. A request bit that is not enabled can still be read at 0x14 while `irq_o` stays low.
- R9: Bits other than 1 and 13 always read zero and ignore writes. Writes to 0x10, and reads or writes to any unmapped address, change nothing. Unmapped addresses read zero.
- R10: An event line held high sets its request bit only once. After software clears the bit, it stays clear until the line falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_done | input | 1 | Completion event level |
| ev_abort | input | 1 | Abort-accepted event level |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Channel interrupt, suitable for wire-OR sharing |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, an 8-bit address, and event bits 1 and 13. With these values every mapped offset is reachable, as are the unmapped addresses above them. An all-ones write therefore exercises all thirty unimplemented bit positions at once. Most of the bench's effort goes into the single-cycle interactions: an event edge that coincides with a clear, an event held high across a clear, and a latched request that is read while masked.

// File: rtl/chan_irq_regs.sv
module chan_irq_regs #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int DONE_BIT  = 1,
  parameter int ABORT_BIT = 13,
  parameter logic [ADDR_W-1:0] OFF_STAT = ADDR_W'('h10),
  parameter logic [ADDR_W-1:0] OFF_REQ  = ADDR_W'('h14),
  parameter logic [ADDR_W-1:0] OFF_EN   = ADDR_W'('h18),
  parameter logic [ADDR_W-1:0] OFF_DET  = ADDR_W'('h1C)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_done,
  input  logic              ev_abort,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] DONE_M  = DATA_W'(1) << DONE_BIT;
  localparam logic [DATA_W-1:0] ABORT_M = DATA_W'(1) << ABORT_BIT;
  localparam logic [DATA_W-1:0] IMPL_M  = DONE_M | ABORT_M;

  logic [DATA_W-1:0] live, prev_q, rise, clr, req_q, en_q, det;

  assign live = (ev_done ? DONE_M : '0) | (ev_abort ? ABORT_M : '0);
  assign rise = live & ~prev_q;
  assign clr  = (bus_wr && bus_addr == OFF_REQ) ? (bus_wdata & IMPL_M) : '0;
  assign det  = req_q & en_q;
  assign irq_o = |det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      req_q  <= '0;
      en_q   <= '0;
    end else begin
      prev_q <= live;
      req_q  <= (req_q & ~clr) | rise;
      if (bus_wr && bus_addr == OFF_EN) en_q <= bus_wdata & IMPL_M;
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_STAT: bus_rdata = live;
      OFF_REQ:  bus_rdata = req_q;
      OFF_EN:   bus_rdata = en_q;
      OFF_DET:  bus_rdata = det;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/chan_irq_regs_chk.sv
module chan_irq_regs_chk #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int DONE_BIT  = 1,
  parameter int ABORT_BIT = 13,
  parameter logic [ADDR_W-1:0] OFF_REQ = ADDR_W'('h14)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_done,
  input logic              ev_abort,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_o,
  input logic [DATA_W-1:0] req_q,
  input logic [DATA_W-1:0] en_q
);
  localparam logic [DATA_W-1:0] IMPL_M = (DATA_W'(1) << DONE_BIT) | (DATA_W'(1) << ABORT_BIT);

  // R3
  abort_latch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q[ABORT_BIT]) |-> $past(ev_abort));

  // R4
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_REQ && bus_wdata[DONE_BIT] && !ev_done) |=> !req_q[DONE_BIT]);

  // R4
  w0_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_REQ && !bus_wdata[DONE_BIT] && req_q[DONE_BIT]) |=> req_q[DONE_BIT]);

  // R8
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_q != '0 && req_q != '0));

  // R9
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~IMPL_M) == '0);
endmodule

bind chan_irq_regs chan_irq_regs_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DONE_BIT(DONE_BIT),
  .ABORT_BIT(ABORT_BIT), .OFF_REQ(OFF_REQ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_abort(ev_abort),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq_o(irq_o), .req_q(req_q), .en_q(en_q)
);

// File: tb/chan_irq_regs_test.sv
`timescale 1ns/1ps
module chan_irq_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ev_done = 0, ev_abort = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int n_run = 0, n_fail = 0;

  localparam logic [7:0] A_ST = 8'h10, A_RQ = 8'h14, A_EN = 8'h18, A_DT = 8'h1C;
  localparam logic [31:0] DN = 32'h2, AB = 32'h2000;

  always #2.5 clk = ~clk;

  chan_irq_regs uut (.clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_abort(ev_abort),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); ev_done = 1;
    @(negedge clk); ev_done = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_RQ, d); chk("R1 req", d, 0);
    rd(A_EN, d); chk("R1 en", d, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    @(negedge clk); ev_done = 1; ev_abort = 1;
    rd(A_ST, d); chk("R2 both live", d, DN | AB);
    ev_abort = 0; rd(A_ST, d); chk("R2 done live", d, DN);
    @(negedge clk); ev_done = 0;
    rd(A_ST, d); chk("R2 none live", d, 0);
    wr(A_RQ, DN | AB);
  endtask

  task automatic t_latch();
    logic [31:0] d;
    pulse_done();
    rd(A_RQ, d); chk("R3 latched after fall", d, DN);
    wr(A_RQ, DN);
    rd(A_RQ, d); chk("R4 cleared", d, 0);
  endtask

  task automatic t_w1c_zero();
    logic [31:0] d;
    @(negedge clk); ev_done = 1; ev_abort = 1;
    @(negedge clk); ev_done = 0; ev_abort = 0;
    wr(A_RQ, DN);
    rd(A_RQ, d); chk("R4 partial clear", d, AB);
    wr(A_RQ, 0);
    rd(A_RQ, d); chk("R4 write zero keeps", d, AB);
    wr(A_RQ, AB);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk); ev_done = 1; bus_wr = 1; bus_addr = A_RQ; bus_wdata = DN;
    @(negedge clk); bus_wr = 0; ev_done = 0;
    rd(A_RQ, d); chk("R5 set wins", d, DN);
    wr(A_RQ, DN);
  endtask

  task automatic t_enable_detect();
    logic [31:0] d;
    wr(A_EN, AB);
    rd(A_EN, d); chk("R6 enable readback", d, AB);
    pulse_done();
    rd(A_RQ, d); chk("R8 polled unmasked req", d, DN);
    chk("R8 irq low when masked", {31'b0, irq_o}, 0);
    rd(A_DT, d); chk("R7 detect masked", d, 0);
    wr(A_EN, DN | AB);
    rd(A_DT, d); chk("R7 detect", d, DN);
    chk("R8 irq high", {31'b0, irq_o}, 1);
    wr(A_DT, 32'hFFFF_FFFF);
    rd(A_RQ, d); chk("R7 detect write ignored", d, DN);
    wr(A_RQ, DN);
    chk("R8 irq drops", {31'b0, irq_o}, 0);
  endtask

  task automatic t_unused();
    logic [31:0] d;
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, d); chk("R9 enable unused bits", d, DN | AB);
    wr(A_ST, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(A_RQ, d); chk("R9 req untouched", d, 0);
    rd(A_EN, d); chk("R9 en untouched", d, DN | AB);
    rd(8'h40, d); chk("R9 unmapped reads zero", d, 0);
    wr(A_EN, 0);
  endtask

  task automatic t_level_hold();
    logic [31:0] d;
    @(negedge clk); ev_abort = 1;
    @(negedge clk);
    rd(A_RQ, d); chk("R10 first set", d, AB);
    wr(A_RQ, AB);
    @(negedge clk); @(negedge clk);
    rd(A_RQ, d); chk("R10 no relatch while high", d, 0);
    ev_abort = 0;
    @(negedge clk); ev_abort = 1;
    @(negedge clk); ev_abort = 0;
    rd(A_RQ, d); chk("R10 relatch on new edge", d, AB);
    wr(A_RQ, AB);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_status();
    t_latch();
    t_w1c_zero();
    t_collide();
    t_enable_detect();
    t_unused();
    t_level_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule